// File: doc/BRIEF.md
# Valid-Ready Clock Domain Bridge

This block carries one data word at a time from a source clock domain to an unrelated destination clock domain. Each side has a level valid/ready handshake. Inside, a single request toggle and a single acknowledge toggle cross the boundary, one in each direction. Each toggle passes through its own flop chain, and this is what provides back pressure.

The source side takes a word into a holding register and flips its request toggle. The destination side sees the request differ from its own acknowledge toggle and raises valid. The captured word waits there until it is taken, and the acknowledge toggle then flips. The source can accept again only once the acknowledge has come back across. The data bus itself crosses without a synchroniser. It is safe because the holding register is frozen for the whole round trip.

The same logic serves a slow destination fed by a fast source and a fast destination fed by a slow source. It is placed between two handshake interfaces that sit in different clock domains.

Top module: `vr_cdc_bridge`

## Requirements
- R1: With both synchronous active-high resets applied, both toggles and both synchroniser chains clear to zero. After release, `src_ready` is 1 and `dst_valid` is 0.
- R2: A word is taken on a source edge where `src_valid` and `src_ready` are both 1. `src_ready` is 0 from the next source cycle on. It stays 0 until the acknowledge toggle, after synchronisation, equals the request toggle again. At most one word is ever in flight.
- R3: While `src_ready` is 0, `src_valid` and `src_data` have no effect. No word is taken, and data offered then never appears at the destination.
- R4: `dst_valid` is 1 exactly when the synchronised request toggle differs from the acknowledge toggle. Whenever `dst_valid` is 1, `dst_data` equals the oldest accepted word that has not yet been delivered. The chain length `SYNC_LEN` must be at least 2.
- R5: Once raised, `dst_valid` and `dst_data` hold steady until `dst_ready` is sampled 1. `dst_valid` is 0 in the cycle after that accepting edge.
- R6: `dst_ready` has no effect while `dst_valid` is 0. The acknowledge toggle does not move, and a word arriving later is still delivered.
- R7: Every accepted word is delivered exactly once, in acceptance order.
- R8: Transfers complete correctly both with the destination clock slower than the source clock and with it faster, with no change to the design.
- R9: Each toggle crosses through a chain of `SYNC_LEN` flops clocked by the receiving side. The chain output is 0 on the cycle after that side's reset is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Bridge can take a word |
| src_data | input | DATA_W | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_valid | output | 1 | A word is waiting at the destination |
| dst_ready | input | 1 | Destination takes the waiting word |
| dst_data | output | DATA_W | Word presented to the destination |

## Verification
The hold checks on `dst_valid` and `dst_data` assume that neither side is reset on its own while a word is in flight. They also assume that both clocks keep running, since the source holding register is trusted to stay frozen until the acknowledge returns. The stimulus therefore applies and releases both resets together, once, before any traffic. It changes the clock ratio only after the bridge has drained and the source is idle. Random valid and ready patterns are used throughout, including valid held while the bridge is busy and ready held while nothing is waiting.

// File: rtl/vr_cdc_pkg.sv
package vr_cdc_pkg;
  // Shortest chain that gives the data bus a settled capture before valid rises.
  localparam int unsigned MIN_CHAIN = 2;

  // Two toggles carry a transfer in flight when they disagree.
  function automatic logic tgl_open(input logic own_tgl, input logic far_tgl);
    return own_tgl ^ far_tgl;
  endfunction
endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic tgl_out
);
  localparam int unsigned LAST = SYNC_LEN - 1;

  logic [SYNC_LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_LEN-2:0], tgl_in};
  end

  assign tgl_out = chain[LAST];

  // R9
  sync_reset_chk: assert property (@(posedge clk) rst |=> (tgl_out == 1'b0));
endmodule

// File: rtl/src_side.sv
module src_side
  import vr_cdc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_sync,
  output logic              req_tgl,
  output logic [DATA_W-1:0] hold_data
);
  logic take;

  assign in_ready = ~tgl_open(req_tgl, ack_sync);
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl   <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      req_tgl   <= ~req_tgl;
      hold_data <= in_data;
    end
  end

  // R2
  src_busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R2
  src_wait_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (!in_ready || (ack_sync != $past(ack_sync))));
  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(hold_data));
endmodule

// File: rtl/dst_side.sv
module dst_side
  import vr_cdc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] xfer_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              ack_tgl
);
  assign out_valid = tgl_open(ack_tgl, req_sync);

  // The data bus is sampled every cycle with no synchroniser; the source
  // holds it frozen from before the request flips until the ack returns.
  always_ff @(posedge clk) begin
    if (rst) out_data <= '0;
    else     out_data <= xfer_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                        ack_tgl <= 1'b0;
    else if (out_valid && out_ready) ack_tgl <= ~ack_tgl;
  end

  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));
  // R5
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid);
  // R6
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> $stable(ack_tgl));
endmodule

// File: rtl/vr_cdc_bridge.sv
module vr_cdc_bridge
  import vr_cdc_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              src_clk,
  input  logic              src_rst,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_clk,
  input  logic              dst_rst,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [DATA_W-1:0] dst_data
);
  localparam int unsigned CHAIN = (SYNC_LEN < MIN_CHAIN) ? MIN_CHAIN : SYNC_LEN;

  logic              req_tgl, req_sync;
  logic              ack_tgl, ack_sync;
  logic [DATA_W-1:0] hold_data;

  src_side #(.DATA_W(DATA_W)) u_src (
    .clk(src_clk), .rst(src_rst),
    .in_valid(src_valid), .in_ready(src_ready), .in_data(src_data),
    .ack_sync(ack_sync), .req_tgl(req_tgl), .hold_data(hold_data)
  );

  toggle_sync #(.SYNC_LEN(CHAIN)) u_req_sync (
    .clk(dst_clk), .rst(dst_rst), .tgl_in(req_tgl), .tgl_out(req_sync)
  );

  toggle_sync #(.SYNC_LEN(CHAIN)) u_ack_sync (
    .clk(src_clk), .rst(src_rst), .tgl_in(ack_tgl), .tgl_out(ack_sync)
  );

  dst_side #(.DATA_W(DATA_W)) u_dst (
    .clk(dst_clk), .rst(dst_rst),
    .req_sync(req_sync), .xfer_data(hold_data),
    .out_valid(dst_valid), .out_ready(dst_ready), .out_data(dst_data),
    .ack_tgl(ack_tgl)
  );

  // R1
  src_reset_ready_chk: assert property (@(posedge src_clk) src_rst |=> src_ready);
  // R1
  dst_reset_idle_chk: assert property (@(posedge dst_clk) dst_rst |=> !dst_valid);
endmodule

// File: tb/sim_vr_cdc_bridge.sv
module sim_vr_cdc_bridge;
  localparam int DW = 8;

  logic          src_clk = 1'b0, dst_clk = 1'b0;
  logic          src_rst, dst_rst;
  logic          src_valid, src_ready, dst_valid, dst_ready;
  logic [DW-1:0] src_data, dst_data;

  int dst_half = 17;
  int n_chk = 0, n_fail = 0;
  int accepted = 0, delivered = 0;
  bit chk_on = 0, src_run = 0, took_last = 0;
  bit pv = 0, pr = 0;
  logic [DW-1:0] pd = '0;
  logic [DW-1:0] exp_q[$];

  vr_cdc_bridge #(.DATA_W(DW), .SYNC_LEN(2)) u0 (
    .src_clk(src_clk), .src_rst(src_rst), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_valid(dst_valid),
    .dst_ready(dst_ready), .dst_data(dst_data)
  );

  always #5 src_clk = ~src_clk;
  always begin #(dst_half) dst_clk = ~dst_clk; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Source-side model: decide at the falling edge, record what the next rising edge takes.
  always @(negedge src_clk) begin
    if (src_run) begin
      src_valid = ($urandom_range(0, 3) != 0);
      src_data  = DW'($urandom);
    end else begin
      src_valid = 1'b0;
    end
    #1;
    if (chk_on) begin
      if (took_last) check(src_ready == 1'b0, "R2 ready after take", src_ready, 0);
      if (src_ready) check(exp_q.size() == 0, "R2 ready while in flight", exp_q.size(), 0);
      // R3: offers made while not ready are never queued and must never be delivered
      if (src_valid && src_ready) begin
        exp_q.push_back(src_data);
        accepted++;
        took_last = 1;
      end else begin
        took_last = 0;
      end
    end
  end

  // Destination-side model.
  always @(negedge dst_clk) begin
    dst_ready = ($urandom_range(0, 2) != 0);
    #1;
    if (chk_on) begin
      if (pv && !pr) begin
        check(dst_valid == 1'b1, "R5 valid held", dst_valid, 1);
        check(dst_data == pd, "R5 data held", dst_data, pd);
      end
      if (pv && pr) check(dst_valid == 1'b0, "R5 valid drop", dst_valid, 0);
      if (dst_valid) begin
        check(exp_q.size() != 0, "R4 valid without word", exp_q.size(), 1);
        if (exp_q.size() != 0) begin
          if (!pv && pr) // R6: ready while idle did not consume this word
            check(dst_data == exp_q[0], "R6 word after idle ready", dst_data, exp_q[0]);
          else
            check(dst_data == exp_q[0], "R4 R7 data order", dst_data, exp_q[0]);
        end
      end
      if (dst_valid && dst_ready) begin
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        delivered++;
      end
      pv = dst_valid;
      pr = dst_ready;
      pd = dst_data;
    end
  end

  initial begin
    src_rst = 1'b1; dst_rst = 1'b1;
    src_valid = 1'b0; src_data = '0; dst_ready = 1'b0;
    repeat (6) @(posedge dst_clk);
    @(negedge src_clk); src_rst = 1'b0;
    @(negedge dst_clk); dst_rst = 1'b0;
    @(negedge src_clk); #2;
    check(src_ready == 1'b1, "R1 src_ready after reset", src_ready, 1);
    check(dst_valid == 1'b0, "R1 dst_valid after reset", dst_valid, 0);
    chk_on = 1;

    // R8 phase A: destination slower than source
    src_run = 1;
    while (delivered < 40) @(posedge src_clk);
    src_run = 0;
    while (exp_q.size() != 0) @(posedge src_clk);
    repeat (20) @(posedge src_clk);
    check(delivered >= 40, "R8 slow destination", delivered, 40);
    check(src_ready == 1'b1, "R2 ready when drained", src_ready, 1);

    // R8 phase B: destination faster than source
    dst_half = 2;
    repeat (20) @(posedge src_clk);
    src_run = 1;
    while (delivered < 100) @(posedge src_clk);
    src_run = 0;
    while (exp_q.size() != 0) @(posedge src_clk);
    repeat (20) @(posedge src_clk);
    check(delivered >= 100, "R8 fast destination", delivered, 100);

    // R7: each accepted word delivered once
    check(accepted == delivered, "R7 count", delivered, accepted);
    check(exp_q.size() == 0, "R7 nothing left", exp_q.size(), 0);
    check(dst_valid == 1'b0, "R5 idle at end", dst_valid, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge src_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d delivered expected 100", delivered);
    summary();
    $finish;
  end
endmodule